// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a successive-approximation converter whose analog parts (input multiplexer, sample-and-hold switch, DAC and comparator) sit outside it. A conversion is requested either by a one-cycle software start strobe or by a rising edge on one of ten external trigger lines. Once a request is accepted, the controller latches the channel, the resolution and the sample length. It closes the sampling switch for the programmed number of cycles, then opens it and runs a most-significant-bit-first binary search. In each step it drives a trial code to the DAC and reads back one comparator bit.

Resolution is chosen per conversion as 8, 10 or 12 bits. The search takes exactly that many decision cycles. The finished code is presented right-aligned in a 12-bit result, together with a one-cycle done pulse and a sticky completion flag. Analog power is enabled only while a conversion runs.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When a request is accepted, `chan_sel` is latched onto `mux_sel` and held there until the next accepted request. Codes 0 to 9 select that input, and codes 10 to 15 select input 9.
- R2: The sample phase begins in the cycle after acceptance. During it, `sh_sample` is high for max(`smp_cycles`+1, 2) consecutive cycles, which gives 2 to 16 cycles.
- R3: `sh_sample` is low whenever the block is idle. Once it falls within a conversion, it stays low until that conversion ends.
- R4: `res_sel` 0 selects 8 bits, 1 selects 10 bits, and 2 or 3 select 12 bits. The decision phase lasts exactly that many cycles, so `busy` is high for sample cycles plus resolution cycles.
- R5: In each decision cycle, `dac_code` equals the bits already kept ORed with the bit under test, working from the top bit of the selected width down to bit 0. The bit is kept when `comp_in` is 1, meaning the input is at or above the DAC level. Outside the decision phase, `dac_code` is 0.
- R6: `result` holds the final code right-aligned, with bits above the selected width zero. An input at the low reference gives all zeros, and an input at the full-scale top gives all ones of the selected width.
- R7: `apwr_en` is high exactly in the cycles where `busy` is high and is low otherwise.
- R8: Trigger line `ext_trig_in[trig_sel]` (codes 10 to 15 select line 9) passes through a two-flop synchronizer and starts a conversion on its rising edge. `busy` first shows high at the third rising clock edge after the line rises. A line held high starts only one conversion.
- R9: A start strobe or trigger edge that arrives while `busy` is high is ignored and does not change the channel, timing or result of the running conversion.
- R10: In the cycle after the last decision, `result` updates, `done` is high for exactly one cycle, and `cmpl` becomes 1. `cmpl` stays 1 until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Software conversion request strobe |
| ext_trig_in | input | 10 | External trigger lines |
| trig_sel | input | 4 | Trigger line select |
| res_sel | input | 2 | Resolution select (0: 8, 1: 10, 2/3: 12 bits) |
| chan_sel | input | 4 | Analog channel select |
| smp_cycles | input | 4 | Sample length code |
| comp_in | input | 1 | Comparator: 1 when input is at or above DAC level |
| mux_sel | output | 4 | Latched channel to analog multiplexer |
| sh_sample | output | 1 | Sample switch closed when high |
| dac_code | output | 12 | Trial code to DAC |
| apwr_en | output | 1 | Analog power enable |
| result | output | 12 | Right-aligned conversion result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |
| cmpl | output | 1 | Sticky completion flag |

## Verification
The bench targets the sample-length edges at codes 0, 1 and 15. A design that got these wrong would sample one cycle too long or too short, and the busy-cycle count would show it. It also drives the rail inputs at every resolution. Here a search that stops one bit early, or that uses the wrong width, leaves a low bit clear or sets stray upper bits. Further cases cover requests made during a conversion, which a faulty design would restart or use to switch channel mid-search. The trigger cases use a held-high line and a line that is not selected: the first would retrigger a level-sensitive design, and the second would start a design whose selection is wrong.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } sar_state_e;

  // Index of the first bit tested for a resolution code, relative to the widest width.
  function automatic int unsigned top_bit_idx(input logic [1:0] code, input int unsigned res_max);
    case (code)
      2'd0:    top_bit_idx = res_max - 5;
      2'd1:    top_bit_idx = res_max - 3;
      default: top_bit_idx = res_max - 1;
    endcase
  endfunction

endpackage

// File: rtl/sar_trig_detect.sv
module sar_trig_detect #(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  output logic              rise_o
);

  logic raw_sel;
  logic sync1_q, sync2_q, prev_q;

  always_comb begin
    raw_sel = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(trig_sel) == i) raw_sel = trig_in[i];
    end
    if (int'(trig_sel) >= NUM_CH) raw_sel = trig_in[NUM_CH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= raw_sel;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise_o = sync2_q & ~prev_q;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_conv_pkg::*;
#(
  parameter int unsigned SMP_W   = 4,
  parameter int unsigned SMP_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [SMP_W-1:0] smp_code,
  input  logic             last_bit,
  output sar_state_e       state_o,
  output logic             accept,
  output logic             enter_conv,
  output logic             finish
);

  localparam logic [SMP_W-1:0] CNT_FLOOR = SMP_W'(SMP_MIN - 1);

  sar_state_e       state_q, state_d;
  logic [SMP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [SMP_W-1:0] smp_load;

  assign smp_load = (smp_code < CNT_FLOOR) ? CNT_FLOOR : smp_code;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    accept     = 1'b0;
    enter_conv = 1'b0;
    finish     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          accept  = 1'b1;
          state_d = ST_SAMPLE;
          cnt_d   = smp_load;
          cnt_en  = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (cnt_q == '0) begin
          enter_conv = 1'b1;
          state_d    = ST_CONVERT;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_CONVERT: begin
        if (last_bit) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_conv_pkg::*;
#(
  parameter int unsigned RES_MAX = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [1:0]         res_code,
  input  logic               enter_conv,
  input  logic               step,
  input  logic               comp_in,
  output logic [RES_MAX-1:0] dac_code,
  output logic               last_bit,
  output logic [RES_MAX-1:0] final_code
);

  logic [RES_MAX-1:0] top_q, top_d;
  logic [RES_MAX-1:0] acc_q, acc_d;
  logic [RES_MAX-1:0] mask_q, mask_d;
  logic               acc_en;
  logic [RES_MAX-1:0] trial;

  always_comb begin
    top_d = '0;
    top_d[top_bit_idx(res_code, RES_MAX)] = 1'b1;
  end

  assign trial = acc_q | mask_q;

  always_comb begin
    acc_d  = acc_q;
    mask_d = mask_q;
    acc_en = 1'b0;
    if (enter_conv) begin
      acc_d  = '0;
      mask_d = top_q;
      acc_en = 1'b1;
    end else if (step) begin
      acc_d  = comp_in ? trial : acc_q;
      mask_d = mask_q >> 1;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
    end else begin
      if (accept) top_q <= top_d;
      if (acc_en) begin
        acc_q  <= acc_d;
        mask_q <= mask_d;
      end
    end
  end

  assign dac_code   = step ? trial : '0;
  assign last_bit   = step & mask_q[0];
  assign final_code = comp_in ? trial : acc_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int unsigned NUM_CH  = 10,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned RES_MAX = 12,
  parameter int unsigned SMP_W   = 4,
  parameter int unsigned SMP_MIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NUM_CH-1:0]  ext_trig_in,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [1:0]         res_sel,
  input  logic [SEL_W-1:0]   chan_sel,
  input  logic [SMP_W-1:0]   smp_cycles,
  input  logic               comp_in,
  output logic [SEL_W-1:0]   mux_sel,
  output logic               sh_sample,
  output logic [RES_MAX-1:0] dac_code,
  output logic               apwr_en,
  output logic [RES_MAX-1:0] result,
  output logic               done,
  output logic               busy,
  output logic               cmpl
);

  localparam logic [SEL_W-1:0] CH_LAST = SEL_W'(NUM_CH - 1);

  sar_state_e         state;
  logic               trig_rise, go, accept, enter_conv, finish, last_bit;
  logic [RES_MAX-1:0] final_code;
  logic [SEL_W-1:0]   mux_q, mux_d;
  logic [RES_MAX-1:0] result_q;
  logic               done_q, cmpl_q, cmpl_d;

  sar_trig_detect #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(ext_trig_in), .trig_sel(trig_sel), .rise_o(trig_rise)
  );

  assign go = start | trig_rise;

  sar_seq_fsm #(.SMP_W(SMP_W), .SMP_MIN(SMP_MIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .smp_code(smp_cycles), .last_bit(last_bit),
    .state_o(state), .accept(accept), .enter_conv(enter_conv), .finish(finish)
  );

  sar_bit_engine #(.RES_MAX(RES_MAX)) u_eng (
    .clk(clk), .rst_n(rst_n), .accept(accept), .res_code(res_sel),
    .enter_conv(enter_conv), .step(state == ST_CONVERT), .comp_in(comp_in),
    .dac_code(dac_code), .last_bit(last_bit), .final_code(final_code)
  );

  assign mux_d  = (chan_sel > CH_LAST) ? CH_LAST : chan_sel;
  assign cmpl_d = finish ? 1'b1 : (accept ? 1'b0 : cmpl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      cmpl_q   <= 1'b0;
    end else begin
      if (accept) mux_q <= mux_d;
      if (finish) result_q <= final_code;
      done_q <= finish;
      cmpl_q <= cmpl_d;
    end
  end

  assign mux_sel   = mux_q;
  assign result    = result_q;
  assign done      = done_q;
  assign cmpl      = cmpl_q;
  assign busy      = (state != ST_IDLE);
  assign apwr_en   = busy;
  assign sh_sample = (state == ST_SAMPLE);

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned RES_MAX = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   mux_sel,
  input logic               sh_sample,
  input logic [RES_MAX-1:0] dac_code,
  input logic               apwr_en,
  input logic               done,
  input logic               busy,
  input logic               cmpl
);

  assert_mux_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_sel) <= 9);

  assert_mux_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  assert_sample_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_sample |-> busy);

  assert_hold_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sh_sample) |=> !sh_sample);

  assert_dac_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || sh_sample) |-> (dac_code == '0));

  assert_power_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    apwr_en == busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmpl && !busy));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.SEL_W(SEL_W), .RES_MAX(RES_MAX)) u_chk (.*);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  ext_trig_in = '0;
  logic [3:0]  trig_sel = 4'd15;
  logic [1:0]  res_sel = 2'd2;
  logic [3:0]  chan_sel = '0;
  logic [3:0]  smp_cycles = '0;
  logic        comp_in;
  logic [3:0]  mux_sel;
  logic        sh_sample;
  logic [11:0] dac_code;
  logic        apwr_en;
  logic [11:0] result;
  logic        done;
  logic        busy;
  logic        cmpl;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int ain [10];

  // behavioural reference state
  int m_ph, m_cnt, m_bit, m_acc, m_w, m_ch, m_res;
  bit m_done, m_cmpl, m_s1, m_s2, m_pv;

  always #2 clk = ~clk;

  sar_conv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_trig_in(ext_trig_in),
    .trig_sel(trig_sel), .res_sel(res_sel), .chan_sel(chan_sel),
    .smp_cycles(smp_cycles), .comp_in(comp_in), .mux_sel(mux_sel),
    .sh_sample(sh_sample), .dac_code(dac_code), .apwr_en(apwr_en),
    .result(result), .done(done), .busy(busy), .cmpl(cmpl)
  );

  // analog stand-in: comparator sees the held channel scaled to the active width
  assign comp_in = ((ain[m_ch] >> (12 - m_w)) >= int'(dac_code));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_bit = 0; m_acc = 0; m_w = 12; m_ch = 0; m_res = 0;
      m_done = 0; m_cmpl = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else begin
      bit edge_now;
      int tsel, trial;
      edge_now = m_s2 && !m_pv;
      tsel = (trig_sel > 9) ? 9 : int'(trig_sel);
      m_pv = m_s2; m_s2 = m_s1; m_s1 = ext_trig_in[tsel];
      m_done = 0;
      case (m_ph)
        0: if (start || edge_now) begin
             m_ph = 1;
             m_ch = (chan_sel > 9) ? 9 : int'(chan_sel);
             m_w = (res_sel == 0) ? 8 : (res_sel == 1) ? 10 : 12;
             m_cnt = (smp_cycles + 1 < 2) ? 2 : int'(smp_cycles) + 1;
             m_cmpl = 0;
           end
        1: begin
             m_cnt--;
             if (m_cnt == 0) begin m_ph = 2; m_bit = m_w - 1; m_acc = 0; end
           end
        default: begin
             trial = m_acc | (1 << m_bit);
             if ((ain[m_ch] >> (12 - m_w)) >= trial) m_acc = trial;
             if (m_bit == 0) begin m_ph = 0; m_res = m_acc; m_done = 1; m_cmpl = 1; end
             else m_bit--;
           end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(mux_sel) == m_ch, "R1 mux_sel", mux_sel, m_ch);
      chk(sh_sample == (m_ph == 1), "R2 sh_sample", sh_sample, m_ph == 1);
      chk(busy == (m_ph != 0), "R4 busy", busy, m_ph != 0);
      chk(int'(dac_code) == ((m_ph == 2) ? (m_acc | (1 << m_bit)) : 0), "R5 dac_code",
          dac_code, (m_ph == 2) ? (m_acc | (1 << m_bit)) : 0);
      chk(int'(result) == m_res, "R6 result", result, m_res);
      chk(apwr_en == (m_ph != 0), "R7 apwr_en", apwr_en, m_ph != 0);
      chk(done == m_done, "R10 done", done, m_done);
      chk(cmpl == m_cmpl, "R10 cmpl", cmpl, m_cmpl);
    end
  end

  task automatic wait_done(output int busy_n, output int sh_n);
    int guard;
    busy_n = 0; sh_n = 0; guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      if (busy) busy_n++;
      if (sh_sample) sh_n++;
      guard++;
    end
    chk(done, "R10 done seen", done, 1);
  endtask

  task automatic sw_conv(input int ch, input int rc, input int sc, input int val, input string tag);
    int bn, sn, w, n, exp;
    ain[(ch > 9) ? 9 : ch] = val;
    @(negedge clk);
    chan_sel = 4'(ch); res_sel = 2'(rc); smp_cycles = 4'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busy) bn = 1; else bn = 0;
    if (sh_sample) sn = 1; else sn = 0;
    begin
      int b2, s2;
      wait_done(b2, s2);
      bn += b2; sn += s2;
    end
    w = (rc == 0) ? 8 : (rc == 1) ? 10 : 12;
    n = (sc + 1 < 2) ? 2 : sc + 1;
    exp = val >> (12 - w);
    chk(int'(result) == exp, {tag, " R6 code"}, result, exp);
    chk(sn == n, {tag, " R2 sample length"}, sn, n);
    chk(bn == n + w, {tag, " R4 busy length"}, bn, n + w);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int bn, sn, lat;
    for (int i = 0; i < 10; i++) ain[i] = 100 * i + 37;
    repeat (3) @(negedge clk);
    chk(!busy && !apwr_en && !sh_sample && dac_code == 0 && result == 0 && !cmpl,
        "reset R7", {busy, apwr_en, sh_sample}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    sw_conv(2, 2, 3, 12'h9A5, "mid12");
    sw_conv(5, 0, 0, 12'h7C3, "r8 smp0");
    sw_conv(7, 1, 1, 12'hABC, "r10 smp1");
    sw_conv(0, 3, 15, 12'h555, "r12 smp15");
    sw_conv(1, 2, 4, 0, "low rail");
    sw_conv(3, 2, 4, 4095, "high rail 12");
    sw_conv(4, 0, 2, 4095, "high rail 8");
    sw_conv(6, 1, 2, 4095, "high rail 10");
    sw_conv(8, 0, 2, 0, "low rail 8");
    sw_conv(12, 2, 2, 12'h3F1, "R1 clamp ch9");
    chk(mux_sel == 4'd9, "R1 clamp", mux_sel, 9);

    // R9: requests during a conversion are ignored
    ain[2] = 12'h321; ain[6] = 12'hFED;
    @(negedge clk);
    chan_sel = 4'd2; res_sel = 2'd2; smp_cycles = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chan_sel = 4'd6; start = 1'b1; trig_sel = 4'd6; ext_trig_in[6] = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    ext_trig_in[6] = 1'b0;
    chk(mux_sel == 4'd2, "R9 channel kept", mux_sel, 2);
    wait_done(bn, sn);
    chk(result == 12'h321, "R9 result from first channel", result, 12'h321);
    repeat (10) @(negedge clk);
    chk(!busy, "R9 no restart", busy, 0);

    // R8: selected trigger line, latency and single start for a held level
    ain[3] = 12'h888; chan_sel = 4'd3; res_sel = 2'd1; smp_cycles = 4'd2; trig_sel = 4'd3;
    @(negedge clk);
    ext_trig_in[3] = 1'b1;
    lat = 0;
    while (!busy && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == 3, "R8 trigger latency", lat, 3);
    wait_done(bn, sn);
    chk(result == 12'h222, "R8 trigger result", result, 12'h222);
    repeat (20) @(negedge clk);
    chk(!busy, "R8 held level single start", busy, 0);
    ext_trig_in[3] = 1'b0;

    // R8: an unselected line does nothing
    ext_trig_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    ext_trig_in[9] = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && !sh_sample, "R8 unselected line ignored", busy, 0);

    // R8: select codes above 9 pick line 9
    trig_sel = 4'd14; chan_sel = 4'd9; ain[9] = 12'hC0F; res_sel = 2'd2;
    @(negedge clk);
    ext_trig_in[9] = 1'b1;
    wait_done(bn, sn);
    chk(result == 12'hC0F, "R8 default line 9", result, 12'hC0F);
    ext_trig_in[9] = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule